// File: doc/BRIEF.md
# Serial Character Transmitter with Holding Register and Status Flags

This block sends characters on a single asynchronous serial line. A one-character holding register sits in front of a frame shift register. Software writes a character into the holding register. The block moves that character into the shifter when the shifter is free and then frames it. A frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Every bit lasts a fixed number of pulses of an external baud tick.

Two status flags are visible. `hold_empty` says the holding register can take a new character. `tx_done` says the line is idle and nothing is waiting. Both flags are cleared by the same sequence. Software first performs a status read while the flag is 1, and the next data write then clears it. A data write that is not preceded by such a read leaves the empty flag at 1, and that character is never sent. Apart from characters, the shifter can also be asked to send one frame-length of ones (an idle preamble) or one frame-length of zeros (a break). These use the same bit timing. Queued items follow one another with no idle gap between them. Pending items are taken in a fixed priority: break first, then preamble, then the held character.

Top module: `sertx_unit`

## Requirements
- R1: After reset, `hold_empty` is 1, `tx_done` is 1 and `tx_line` is 1.
- R2: A character is sent as one low start bit, DATA_W data bits least significant first, and one high stop bit (no parity with the default PARITY_MODE = 0). Each bit lasts TICKS_PER_BIT baud ticks (default 16), and `tx_line` changes only on a baud tick while a frame is in progress.
- R3: `hold_empty` becomes 1 on the same clock edge at which the held character is loaded into the shift register.
- R4: A data write while `hold_empty` is 0 replaces the held character, and only the most recent character is sent.
- R5: A data write while `hold_empty` is 1, with no status read since the last data write that saw it at 1, leaves `hold_empty` at 1. The character is not sent and `tx_line` stays high.
- R6: A status read that sees a flag at 1, followed by a data write, clears that flag on the write's clock edge. This applies to `hold_empty` and to `tx_done`.
- R7: `tx_done` is 1 only while no frame is in progress and no character, preamble or break is pending. It returns to 1 once all queued items have been sent.
- R8: A pulse on `idle_req` sends one frame-length (FRAME_W × TICKS_PER_BIT ticks) of ones. A pulse on `break_req` sends one frame-length of zeros, which is 160 ticks with the defaults.
- R9: When an item is pending as a frame ends, the next frame starts on the tick that ends the current one, with no idle gap.
- R10: When several items are pending, the break is sent first, then the preamble, then the held character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per baud sub-period |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| data_wr | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Character to write into the holding register |
| idle_req | input | 1 | Request one frame of ones |
| break_req | input | 1 | Request one frame of zeros |
| tx_line | output | 1 | Serial output, high when idle |
| hold_empty | output | 1 | Holding register may be written |
| tx_done | output | 1 | Transmitter idle and nothing queued |

## Verification
The flag sequencing is exercised in several ways. Writes arrive with and without a preceding status read, which separates the armed clear from the ignored write. Overwrites happen while a character is still held, which shows whether the last write or the first one is sent. Characters are framed with the baud tick on every clock and with a tick every third clock, which separates a bit length counted in ticks from one counted in clocks. Break, preamble and character are queued together and measured as runs of line level. Those run lengths show the priority order, the frame length of fill frames, and whether an idle gap appears between back-to-back frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // source selected for the next frame
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_DATA  = 2'd1,
      SRC_FILL1 = 2'd2,
      SRC_FILL0 = 2'd3
   } src_e;

   // start + data + optional parity + stop
   function automatic int frame_len(input int data_w, input int parity_mode);
      return data_w + 2 + ((parity_mode != 0) ? 1 : 0);
   endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_data,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_empty,
   output logic              arm_h
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         hold_empty <= 1'b1;
         arm_h      <= 1'b0;
      end else begin
         if (data_wr)
            hold_q <= wr_data;
         if (data_wr)
            arm_h <= 1'b0;
         else if (stat_rd && hold_empty)
            arm_h <= 1'b1;
         if (load_data)
            hold_empty <= 1'b1;
         else if (data_wr && arm_h)
            hold_empty <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_sched.sv
module sertx_sched
   import sertx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic data_wr,
   input  logic idle_req,
   input  logic break_req,
   input  logic hold_empty,
   input  logic busy,
   input  logic frame_end,
   output logic load,
   output src_e sel,
   output logic load_data,
   output logic load_brk,
   output logic tx_done
);

   logic fill1_q, fill0_q, arm_t;
   logic any_pend, idle_now;

   assign any_pend  = fill0_q | fill1_q | ~hold_empty;
   assign load      = any_pend && (!busy || frame_end);
   assign sel       = fill0_q ? SRC_FILL0 :
                      fill1_q ? SRC_FILL1 :
                      (!hold_empty ? SRC_DATA : SRC_NONE);
   assign load_data = load && (sel == SRC_DATA);
   assign load_brk  = load && (sel == SRC_FILL0);
   assign idle_now  = !busy && hold_empty && !fill1_q && !fill0_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill1_q <= 1'b0;
         fill0_q <= 1'b0;
         arm_t   <= 1'b0;
         tx_done <= 1'b1;
      end else begin
         if (load_brk)
            fill0_q <= 1'b0;
         if (break_req)
            fill0_q <= 1'b1;
         if (load && (sel == SRC_FILL1))
            fill1_q <= 1'b0;
         if (idle_req)
            fill1_q <= 1'b1;
         if (data_wr)
            arm_t <= 1'b0;
         else if (stat_rd && tx_done)
            arm_t <= 1'b1;
         if ((data_wr && arm_t) || idle_req || break_req || !idle_now)
            tx_done <= 1'b0;
         else
            tx_done <= 1'b1;
      end
   end

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
   import sertx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PARITY_MODE = 0,
   parameter int FRAME_W     = 10
) (
   input  src_e               sel,
   input  logic [DATA_W-1:0]  data,
   output logic [FRAME_W-1:0] frame
);

   logic [FRAME_W-1:0] char_frame;

   generate
      if (PARITY_MODE == 0) begin : g_nopar
         assign char_frame = {1'b1, data, 1'b0};
      end else begin : g_par
         logic par_bit;
         // 1: even parity, 2: odd parity
         assign par_bit    = (^data) ^ (PARITY_MODE == 2);
         assign char_frame = {1'b1, par_bit, data, 1'b0};
      end
   endgenerate

   always_comb begin
      case (sel)
         SRC_FILL0: frame = '0;
         SRC_FILL1: frame = '1;
         default:   frame = char_frame;
      endcase
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int FRAME_W       = 10,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   output logic               busy,
   output logic               frame_end,
   output logic               tx_line
);

   localparam int TW = $clog2(TICKS_PER_BIT);
   localparam int BW = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sr;
   logic [TW-1:0]      tcnt;
   logic [BW-1:0]      bcnt;
   logic               bit_end;

   assign bit_end   = busy && baud_tick && (tcnt == TW'(TICKS_PER_BIT - 1));
   assign frame_end = bit_end && (bcnt == BW'(FRAME_W - 1));
   assign tx_line   = busy ? sr[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '1;
         tcnt <= '0;
         bcnt <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sr   <= frame_in;
         tcnt <= '0;
         bcnt <= '0;
         busy <= 1'b1;
      end else if (frame_end) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (bit_end) begin
         sr   <= sr >> 1;
         bcnt <= bcnt + 1'b1;
         tcnt <= '0;
      end else if (busy && baud_tick) begin
         tcnt <= tcnt + 1'b1;
      end
   end

endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
   import sertx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int PARITY_MODE   = 0,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              idle_req,
   input  logic              break_req,
   output logic              tx_line,
   output logic              hold_empty,
   output logic              tx_done
);

   localparam int FRAME_W = frame_len(DATA_W, PARITY_MODE);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("sertx_unit: DATA_W must be 5..9");
      end
      if (PARITY_MODE < 0 || PARITY_MODE > 2) begin : g_bad_parity
         $error("sertx_unit: PARITY_MODE must be 0, 1 or 2");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("sertx_unit: TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0]  hold_q;
   logic [FRAME_W-1:0] frame;
   logic               arm_h, load, load_data, load_brk, busy, frame_end;
   src_e               sel;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_wr(data_wr),
      .wr_data(wr_data), .load_data(load_data), .hold_q(hold_q),
      .hold_empty(hold_empty), .arm_h(arm_h)
   );

   sertx_sched u_sched (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_wr(data_wr),
      .idle_req(idle_req), .break_req(break_req), .hold_empty(hold_empty),
      .busy(busy), .frame_end(frame_end), .load(load), .sel(sel),
      .load_data(load_data), .load_brk(load_brk), .tx_done(tx_done)
   );

   sertx_frame #(.DATA_W(DATA_W), .PARITY_MODE(PARITY_MODE), .FRAME_W(FRAME_W)) u_frame (
      .sel(sel), .data(hold_q), .frame(frame)
   );

   sertx_shift #(.FRAME_W(FRAME_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
      .frame_in(frame), .busy(busy), .frame_end(frame_end), .tx_line(tx_line)
   );

endmodule

// File: rtl/sertx_unit_chk.sv
module sertx_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic data_wr,
   input logic tx_line,
   input logic hold_empty,
   input logic tx_done,
   input logic busy,
   input logic load_data,
   input logic load_brk,
   input logic arm_h
);

   p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(tx_line));

   p_empty_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_data |=> hold_empty);

   p_unarmed_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && hold_empty && !arm_h) |=> hold_empty);

   p_armed_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && arm_h && !load_data) |=> !hold_empty);

   p_idle_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (tx_line && !busy));

   p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_brk |=> !tx_line);

endmodule

bind sertx_unit sertx_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .data_wr(data_wr),
   .tx_line(tx_line), .hold_empty(hold_empty), .tx_done(tx_done),
   .busy(busy), .load_data(load_data), .load_brk(load_brk), .arm_h(arm_h)
);

// File: tb/sertx_unit_bench.sv
module sertx_unit_bench;

   localparam int DW    = 8;
   localparam int TPB   = 16;
   localparam int FRM   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic stat_rd = 1'b0, data_wr = 1'b0, idle_req = 1'b0, break_req = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic tx_line, hold_empty, tx_done;

   int n_chk = 0, n_bad = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   bit cmp_en = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sertx_unit u_sertx_unit (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .stat_rd(stat_rd),
      .data_wr(data_wr), .wr_data(wr_data), .idle_req(idle_req),
      .break_req(break_req), .tx_line(tx_line), .hold_empty(hold_empty),
      .tx_done(tx_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // baud tick pattern
   always @(negedge clk) begin
      tick_cnt = tick_cnt + 1;
      baud_tick <= ((tick_cnt % tick_div) == 0);
   end

   // ---------------- behavioural reference model ----------------
   bit m_hre = 1, m_tc = 1, m_armh = 0, m_armt = 0, m_pre = 0, m_brk = 0;
   logic [DW-1:0] m_hold = '0;
   bit q[$];
   int m_tick = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hre = 1; m_tc = 1; m_armh = 0; m_armt = 0; m_pre = 0; m_brk = 0;
         m_hold = '0; q.delete(); m_tick = 0;
      end else begin
         bit busy, fend, ld, idle, n_tc, n_armh, n_armt, n_hre;
         busy = (q.size() != 0);
         fend = busy && baud_tick && (m_tick == TPB - 1) && (q.size() == 1);
         ld   = (m_brk || m_pre || !m_hre) && (!busy || fend);
         idle = !busy && m_hre && !m_pre && !m_brk;
         n_tc   = !((data_wr && m_armt) || idle_req || break_req || !idle);
         n_armt = data_wr ? 0 : ((stat_rd && m_tc) ? 1 : m_armt);
         n_armh = data_wr ? 0 : ((stat_rd && m_hre) ? 1 : m_armh);
         n_hre  = (ld && !m_brk && !m_pre) ? 1 : ((data_wr && m_armh) ? 0 : m_hre);
         if (busy && baud_tick) begin
            m_tick++;
            if (m_tick == TPB) begin
               m_tick = 0;
               void'(q.pop_front());
            end
         end
         if (ld) begin
            q.delete();
            m_tick = 0;
            if (m_brk) begin
               for (int i = 0; i < FRM; i++) q.push_back(1'b0);
               m_brk = 0;
            end else if (m_pre) begin
               for (int i = 0; i < FRM; i++) q.push_back(1'b1);
               m_pre = 0;
            end else begin
               q.push_back(1'b0);
               for (int i = 0; i < DW; i++) q.push_back(m_hold[i]);
               q.push_back(1'b1);
            end
         end
         if (break_req) m_brk = 1;
         if (idle_req)  m_pre = 1;
         if (data_wr)   m_hold = wr_data;
         m_tc = n_tc; m_armt = n_armt; m_armh = n_armh; m_hre = n_hre;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R2 line vs model", int'(tx_line), (q.size() != 0) ? int'(q[0]) : 1);
         chk("R3 hold_empty vs model", int'(hold_empty), int'(m_hre));
         chk("R7 tx_done vs model", int'(tx_done), int'(m_tc));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic do_rd();
      @(negedge clk); #1 stat_rd = 1'b1;
      @(negedge clk); #1 stat_rd = 1'b0;
   endtask

   task automatic do_wr(input logic [DW-1:0] d);
      @(negedge clk); #1 data_wr = 1'b1; wr_data = d;
      @(negedge clk); #1 data_wr = 1'b0;
   endtask

   task automatic pulse_brk();
      @(negedge clk); #1 break_req = 1'b1;
      @(negedge clk); #1 break_req = 1'b0;
   endtask

   task automatic pulse_pre();
      @(negedge clk); #1 idle_req = 1'b1;
      @(negedge clk); #1 idle_req = 1'b0;
   endtask

   task automatic wait_level(input logic v);
      int g = 0;
      while (tx_line !== v && g < 5000) begin @(negedge clk); g++; end
   endtask

   task automatic run_len(input logic v, output int len);
      len = 0;
      while (tx_line === v && len < 5000) begin len++; @(negedge clk); end
   endtask

   // waits for a start bit, samples mid-bit, returns the data byte
   task automatic grab(input int div, output logic [DW-1:0] d, output logic st, output logic sp);
      wait_level(1'b0);
      repeat (8 * div) @(negedge clk);
      st = tx_line;
      for (int k = 0; k < DW; k++) begin
         repeat (16 * div) @(negedge clk);
         d[k] = tx_line;
      end
      repeat (16 * div) @(negedge clk);
      sp = tx_line;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [DW-1:0] d;
      logic st, sp;
      int len, lows;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;
      // R1 reset state
      chk("R1 hold_empty after reset", int'(hold_empty), 1);
      chk("R1 tx_done after reset", int'(tx_done), 1);
      chk("R1 line after reset", int'(tx_line), 1);

      // R2 framing with a slow tick (one tick per 3 clocks)
      tick_div = 3;
      do_rd();
      do_wr(8'hA5);
      grab(3, d, st, sp);
      chk("R2 start bit", int'(st), 0);
      chk("R2 data bits slow tick", int'(d), 'hA5);
      chk("R2 stop bit", int'(sp), 1);
      repeat (200) @(negedge clk);
      tick_div = 1;
      repeat (4) @(negedge clk);

      // R6 clear by read then write, R3 set on load
      do_rd();
      @(negedge clk); #1 data_wr = 1'b1; wr_data = 8'h5A;
      @(negedge clk);
      chk("R6 hold_empty cleared by armed write", int'(hold_empty), 0);
      chk("R6 tx_done cleared by armed write", int'(tx_done), 0);
      #1 data_wr = 1'b0;
      wait_level(1'b0);
      chk("R3 hold_empty set when frame loads", int'(hold_empty), 1);
      chk("R7 tx_done low during frame", int'(tx_done), 0);
      repeat (300) @(negedge clk);
      chk("R7 tx_done back after frame", int'(tx_done), 1);

      // R4 overwrite while held
      do_rd();
      do_wr(8'hFF);
      wait_level(1'b0);
      do_rd();
      do_wr(8'h81);
      do_wr(8'h3C);
      wait_level(1'b1);
      grab(1, d, st, sp);
      chk("R4 last written character sent", int'(d), 'h3C);
      repeat (300) @(negedge clk);

      // R5 write without status read is ignored
      chk("R5 idle before unarmed write", int'(hold_empty), 1);
      do_wr(8'h55);
      lows = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (tx_line === 1'b0) lows++;
      end
      chk("R5 no frame after unarmed write", lows, 0);
      chk("R5 hold_empty stays set", int'(hold_empty), 1);

      // R8 preamble: line stays high, tx_done drops then returns
      pulse_pre();
      chk("R8 tx_done low while preamble queued", int'(tx_done), 0);
      lows = 0;
      for (int i = 0; i < 250; i++) begin
         @(negedge clk);
         if (tx_line === 1'b0) lows++;
      end
      chk("R8 preamble keeps line high", lows, 0);
      chk("R8 tx_done after preamble", int'(tx_done), 1);

      // R8 break length
      pulse_brk();
      wait_level(1'b0);
      run_len(1'b0, len);
      chk("R8 break low length", len, FRM * TPB);
      repeat (20) @(negedge clk);

      // R9 no gap: zero character, then a break queued mid-frame
      do_rd();
      do_wr(8'h00);
      wait_level(1'b0);
      pulse_brk();
      run_len(1'b0, len);
      run_len(1'b1, len);
      chk("R9 stop bit then break with no gap", len, TPB);
      run_len(1'b0, len);
      chk("R9 break follows at once", len, FRM * TPB);
      repeat (40) @(negedge clk);

      // R10 priority: break, then preamble, then character
      do_rd();
      @(negedge clk); #1 data_wr = 1'b1; wr_data = 8'h96; idle_req = 1'b1; break_req = 1'b1;
      @(negedge clk); #1 data_wr = 1'b0; idle_req = 1'b0; break_req = 1'b0;
      wait_level(1'b0);
      run_len(1'b0, len);
      chk("R10 break first", len, FRM * TPB);
      run_len(1'b1, len);
      chk("R10 preamble second", len, FRM * TPB);
      grab(1, d, st, sp);
      chk("R10 character last", int'(d), 'h96);
      repeat (100) @(negedge clk);
      chk("R7 idle at end", int'(tx_done), 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule